// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter

The block decides which of up to eight bus masters owns a shared bus. Three of the eight request slots are populated: masters 0, 2 and 3. The other slots are never granted. Each populated master has an effective priority from 0 to 7, where 0 is the most urgent. That value is either a fixed built-in level of 7 or a 3-bit level that software has written. A per-master enable bit selects between the two.

Software reaches two 32-bit registers through a simple write/read port with a one-bit register select. The first is a priority table with one nibble per master. The second is the enable mask. Grants are registered and one-hot, and the owner keeps the bus for as long as it holds its request. When the owner lets go, the arbiter picks again among the requesters. A register write changes the choice from the clock after the write.

Top module: `prio_arbiter`

## Requirements
- R1: After reset `gnt` is all zero, the priority table (select 0) reads 0x77777777 and the enable mask (select 1) reads 0x00000000.
- R2: The priority table is selected by `cfg_sel`=0. Master n's level is held in bits 4n+2..4n. Bit 4n+3 always reads 0, so writing 0xFFFFFFFF reads back 0x77777777.
- R3: The enable mask is selected by `cfg_sel`=1. Bit 0 enables master 0, bit 2 master 2 and bit 3 master 3. All other bits read 0, so writing 0xFFFFFFFF reads back 0x0000000D.
- R4: A master's effective level is its table field when its enable bit is 1, and 7 when the bit is 0. A lower value wins.
- R5: Among the requesters that may be granted, the one with the lowest effective level wins. On a tie the lowest master index wins.
- R6: `gnt` is registered and has at most one bit set. It only ever grants masters 0, 2 and 3, and only when that master requested in the previous cycle. Requests on slots 1 and 4 to 7 are ignored.
- R7: While the current owner keeps its request high, `gnt` does not change, even if a more urgent master requests. When the owner drops its request, the next grant is chosen from the requests of that cycle.
- R8: When no populated master requests, `gnt` becomes all zero on the next clock.
- R9: A register write is written on clock edge k. The arbitration decided on edge k uses the old contents, and the decision on edge k+1 uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = priority table, 1 = enable mask |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| req | input | 8 | Per-master bus requests |
| gnt | output | 8 | Registered one-hot bus grant |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:

- **Ties between equal levels.** Several masters share the same level after reset and again after all fields are cleared. A design that broke ties in the wrong direction would grant master 3 instead of master 0.
- **Ownership.** The bench raises a more urgent request while an owner still holds the bus. A design that preempts would switch `gnt` early. A design that never rearbitrates would keep the stale owner after it lets go.
- **Reserved and unpopulated bits.** The bench writes all-ones to both registers and requests only unused slots. A design that stored reserved bits would read back extra ones, and a design that did not mask the request slots would grant a master that does not exist.
- **Write-to-effect timing.** A write and a fresh request land in the same cycle. A design that applied the new value too early, or one cycle too late, would grant a different master on the edges either side of the write.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int unsigned PORTS   = 8;
  localparam int unsigned PRIO_W  = 3;
  localparam int unsigned CFG_W   = 32;
  localparam logic [PORTS-1:0] POPULATED = 8'b0000_1101;

  typedef enum logic {
    SEL_PRIO = 1'b0,
    SEL_MASK = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/prio_regs.sv
module prio_regs #(
  parameter int unsigned N     = 8,
  parameter int unsigned PW    = 3,
  parameter int unsigned DW    = 32,
  parameter logic [N-1:0] IMPL = '1,
  parameter logic [PW-1:0] RST_LVL = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 sel,
  input  logic [DW-1:0]        wdata,
  output logic [N-1:0][PW-1:0] lvl_o,
  output logic [N-1:0]         en_o,
  output logic [DW-1:0]        rdata
);
  import prio_arb_pkg::*;
  localparam int unsigned NIB = DW / N;

  logic                 lvl_we;
  logic                 en_we;
  logic [N-1:0][PW-1:0] lvl_q;
  logic [N-1:0]         en_q;
  logic [DW-1:0]        tbl_view;

  assign lvl_we = we && (sel == SEL_PRIO);
  assign en_we  = we && (sel == SEL_MASK);

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q[i] <= RST_LVL;
      else if (lvl_we) lvl_q[i] <= wdata[i*NIB +: PW];
    end

    if (IMPL[i]) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q[i] <= 1'b0;
        else if (en_we) en_q[i] <= wdata[i];
      end
    end else begin : g_noen
      assign en_q[i] = 1'b0;
    end

    assign tbl_view[i*NIB +: NIB] = {{(NIB-PW){1'b0}}, lvl_q[i]};
  end

  always_comb begin
    if (sel == SEL_MASK) rdata = {{(DW-N){1'b0}}, en_q};
    else                 rdata = tbl_view;
  end

  assign lvl_o = lvl_q;
  assign en_o  = en_q;
endmodule

// File: rtl/prio_eval.sv
module prio_eval #(
  parameter int unsigned N     = 8,
  parameter int unsigned PW    = 3,
  parameter logic [N-1:0] IMPL = '1,
  parameter logic [PW-1:0] HARD_LVL = '1
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][PW-1:0] lvl,
  input  logic [N-1:0]         en,
  output logic [N-1:0]         elig,
  output logic [N-1:0][PW-1:0] eff
);
  for (genvar i = 0; i < N; i++) begin : g_eval
    assign elig[i] = req[i] & IMPL[i];
    assign eff[i]  = en[i] ? lvl[i] : HARD_LVL;
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 3
) (
  input  logic [N-1:0]         elig,
  input  logic [N-1:0][PW-1:0] eff,
  output logic [N-1:0]         pick
);
  logic [PW-1:0] best;
  logic          found;

  always_comb begin
    pick  = '0;
    best  = '1;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || eff[i] < best)) begin
        pick  = '0;
        pick[i] = 1'b1;
        best  = eff[i];
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
  import prio_arb_pkg::*;
#(
  parameter int unsigned N      = PORTS,
  parameter int unsigned PW     = PRIO_W,
  parameter int unsigned DW     = CFG_W,
  parameter logic [N-1:0] IMPL  = POPULATED,
  parameter logic [PW-1:0] HARD_LVL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [N-1:0][PW-1:0] lvl;
  logic [N-1:0]         en;
  logic [N-1:0]         elig;
  logic [N-1:0][PW-1:0] eff;
  logic [N-1:0]         pick;
  logic [N-1:0]         gnt_q;
  logic                 owner_holds;
  logic                 gnt_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  prio_regs #(.N(N), .PW(PW), .DW(DW), .IMPL(IMPL), .RST_LVL(HARD_LVL)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .lvl_o (lvl),
    .en_o  (en),
    .rdata (cfg_rdata)
  );

  prio_eval #(.N(N), .PW(PW), .IMPL(IMPL), .HARD_LVL(HARD_LVL)) u_eval (
    .req  (req),
    .lvl  (lvl),
    .en   (en),
    .elig (elig),
    .eff  (eff)
  );

  prio_pick #(.N(N), .PW(PW)) u_pick (
    .elig (elig),
    .eff  (eff),
    .pick (pick)
  );

  assign owner_holds = |(gnt_q & req);
  assign gnt_ce      = !owner_holds;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  gnt_q <= '0;
    else if (gnt_ce) gnt_q <= pick;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32,
  parameter logic [N-1:0] IMPL = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_sel,
  input logic [DW-1:0] cfg_rdata,
  input logic [N-1:0]  req,
  input logic [N-1:0]  gnt
);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_populated_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~IMPL) == '0);

  p_grant_to_requester_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gnt & ~$past(req)) == '0);

  p_owner_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (gnt & req) != '0) |=> gnt == $past(gnt));

  p_idle_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req & IMPL) == '0 |=> gnt == '0);

  p_mask_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> (cfg_rdata & ~{{(DW-N){1'b0}}, IMPL}) == '0);
endmodule

bind prio_arbiter prio_arbiter_chk #(.N(N), .DW(DW), .IMPL(IMPL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_sel   (cfg_sel),
  .cfg_rdata (cfg_rdata),
  .req       (req),
  .gnt       (gnt)
);

// File: tb/sim_prio_arbiter.sv
`timescale 1ns/1ps
module sim_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [7:0]  req;
  logic [7:0]  gnt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  prio_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req), .gnt(gnt)
  );

  // monitor: compare grant against the oldest expected item
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (gnt !== it.exp) begin
        errors++;
        $display("FAIL %s gnt=%b expected=%b", it.tag, gnt, it.exp);
      end
    end
  end

  // driver: one clock of stimulus, expected grant after the edge
  task automatic cyc(input logic we, input logic sel, input logic [31:0] d,
                     input logic [7:0] r, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = d; req = r;
    @(posedge clk);
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #1 cfg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    #0.5 cfg_sel = sel;
    #0.5;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata=%h expected=%h", tag, cfg_rdata, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; req = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    checks++;
    if (gnt !== 8'h00) begin errors++; $display("FAIL R1 gnt=%b expected=00000000", gnt); end
    rd(1'b0, 32'h7777_7777, "R1 table");
    rd(1'b1, 32'h0000_0000, "R1 mask");

    // hardwired levels, tie-break, ownership
    cyc(0, 0, 0, 8'b0000_0000, 8'b0000_0000, "R8 idle");
    cyc(0, 0, 0, 8'b0000_1101, 8'b0000_0001, "R5 tie lowest index");
    cyc(0, 0, 0, 8'b0000_1101, 8'b0000_0001, "R7 hold");
    cyc(0, 0, 0, 8'b0000_1100, 8'b0000_0100, "R7 rearbitrate on drop");
    cyc(0, 0, 0, 8'b0000_1101, 8'b0000_0100, "R7 no preempt");
    cyc(0, 0, 0, 8'b0000_1000, 8'b0000_1000, "R5 single requester");
    cyc(0, 0, 0, 8'b0000_0000, 8'b0000_0000, "R8 release");
    cyc(0, 0, 0, 8'b1111_0010, 8'b0000_0000, "R6 unpopulated ignored");

    // register layouts
    cyc(1, 0, 32'hFFFF_FFFF, 8'h00, 8'h00, "R2 write ones");
    rd(1'b0, 32'h7777_7777, "R2 nibble top bits zero");
    cyc(1, 0, 32'h0000_1234, 8'h00, 8'h00, "R2 write fields");
    rd(1'b0, 32'h0000_1234, "R2 field readback");
    cyc(1, 1, 32'hFFFF_FFFF, 8'h00, 8'h00, "R3 write ones");
    rd(1'b1, 32'h0000_000D, "R3 reserved bits zero");

    // R4 programmed levels: m0=4, m2=2, m3=1
    cyc(0, 0, 0, 8'b0000_1101, 8'b0000_1000, "R4 programmed m3 wins");
    cyc(0, 0, 0, 8'b0000_0000, 8'b0000_0000, "R8 release");
    cyc(0, 0, 0, 8'b0000_0101, 8'b0000_0100, "R4 m2 beats m0");
    cyc(0, 0, 0, 8'b0000_0000, 8'b0000_0000, "R8 release");

    // R9: write all-zero levels on the same edge as a fresh request
    cyc(1, 0, 32'h0000_0000, 8'b0000_1101, 8'b0000_1000, "R9 old levels on write edge");
    cyc(0, 0, 0, 8'b0000_0000, 8'b0000_0000, "R8 release");
    cyc(0, 0, 0, 8'b0000_1101, 8'b0000_0001, "R9 new levels next edge");
    cyc(0, 0, 0, 8'b0000_0000, 8'b0000_0000, "R8 release");

    // R4: only m2 enabled; m3 field 0 is not used
    cyc(1, 1, 32'h0000_0004, 8'h00, 8'h00, "R4 mask m2 only");
    cyc(0, 0, 0, 8'b0000_1101, 8'b0000_0100, "R4 disabled uses fixed 7");
    cyc(0, 0, 0, 8'b0000_0000, 8'b0000_0000, "R8 release");
    cyc(0, 0, 0, 8'b0000_1001, 8'b0000_0001, "R4 fixed tie lowest index");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule